// File: doc/BRIEF.md
# Two-Wire Sensor Register Target

This block is the serial front end of a small sensor register bank. It watches an oversampled two-wire bus (clock line and data line, both sampled on the system clock). It answers a 7-bit address that joins a fixed upper nibble of 1001 with three board strap inputs, so up to eight copies can share one bus. It drives the data line through a single open-drain enable: when `sda_drive_low` is 1, the line is pulled low. Otherwise the line is released.

The master first writes a pointer byte that selects one of four registers. It can then write data bytes into the selected register, most significant byte first. A read returns the selected register, most significant byte first, and repeats the same bytes in order for as long as the master keeps acknowledging. The pointer is held between transactions. The register bank sits outside this block. The block shows the bank the selected index and reads back a combinational read word, and it issues byte-wide write strobes.

Top module: `sensor_i2c_target`

## Requirements
- R1: A START (SDA falls while SCL is high) starts a new address phase from any state, including a repeated START with no STOP before it. The target has released SDA by the cycle after the START is detected.
- R2: A STOP (SDA rises while SCL is high) returns the target to idle with SDA released. A byte cut off by a STOP makes no register write.
- R3: The target acknowledges an address byte `{1,0,0,1, addr_strap[2:0], rw}` by pulling SDA low for the whole ninth SCL period. rw=1 means read and rw=0 means write. A change of `addr_strap` changes the address the target answers.
- R4: After any other address byte, the target does not acknowledge and never drives SDA, and it makes no register write until the next START or STOP.
- R5: In a write, the target acknowledges every byte. The first byte after the address is the pointer byte.
- R6: A pointer byte whose bits [7:2] are not all zero is still acknowledged, but `reg_sel` keeps its old value. Later data bytes in that transaction go to the register already selected.
- R7: Each data byte after the pointer makes one write strobe to register `reg_sel`. `reg_wr_byte` is 0 for bits [15:8] and 1 for bits [7:0]. Byte order starts at 0 for each transaction and wraps from 1 back to 0.
- R8: A read sends the selected register MSB first, bits [15:8] then [7:0]. While the master acknowledges, further bytes wrap back to [15:8].
- R9: When the master does not acknowledge (SDA high in the ninth clock) after a read byte, the target stops driving SDA until the next START or STOP.
- R10: `reg_sel` resets to 0 and keeps its value across transactions, so a read with no pointer write returns the last selected register.
- R11: `sda_drive_low` changes only in the cycle after a detected falling edge of the synchronised SCL.
- R12: `reg_wr_en` is a single-cycle pulse.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8x the SCL rate |
| rst | input | 1 | Synchronous active-high reset |
| scl_in | input | 1 | Raw bus clock line |
| sda_in | input | 1 | Raw bus data line (resolved bus value) |
| addr_strap | input | STRAP_BITS | Low address bits from board straps |
| sda_drive_low | output | 1 | Open-drain enable, 1 pulls SDA low |
| reg_sel | output | PTR_BITS | Current pointer, selects the register to access |
| reg_rd_data | input | 8*DATA_BYTES | Contents of the register selected by `reg_sel` |
| reg_wr_en | output | 1 | One-cycle write strobe |
| reg_wr_byte | output | IDX_W | Byte lane of the write, 0 = most significant |
| reg_wr_data | output | 8 | Byte to write |

## Verification
The hardest condition to reach from the ports is a repeated START that arrives while the target still holds transaction state. Examples are a write that has just loaded the pointer, or a read that the master has ended with a NACK. In those cases the pointer must survive, the byte order must restart, and the target must release the line, all without a STOP in between. The bench reaches these cases with transaction tasks that can leave out the closing STOP and that keep clocking after a NACK. It mixes them with seeded random reads and writes that carry random pointer bytes, some of them malformed, and random lengths that cross the byte wrap in both directions.

// File: rtl/sensor_i2c_pkg.sv
package sensor_i2c_pkg;

  // Protocol phases of the bus target
  typedef enum logic [2:0] {
    ST_IDLE,
    ST_ADDR,
    ST_ADDR_ACK,
    ST_WR_BYTE,
    ST_WR_ACK,
    ST_RD_BYTE,
    ST_RD_ACK,
    ST_IGNORE
  } link_state_t;

  localparam int BYTE_W = 8;

endpackage

// File: rtl/sensor_i2c_sync.sv
// Synchroniser for both bus lines plus edge and bus-condition detection.
module sensor_i2c_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic scl_in,
  input  logic sda_in,
  output logic sda_lvl,
  output logic scl_rise,
  output logic scl_fall,
  output logic start_evt,
  output logic stop_evt
);

  // [SYNC_STAGES-1] is the synchronised level, [SYNC_STAGES] is its previous value
  logic [SYNC_STAGES:0] scl_pipe;
  logic [SYNC_STAGES:0] sda_pipe;
  logic scl_now, scl_old, sda_now, sda_old;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_pipe <= '1;
      sda_pipe <= '1;
    end else begin
      scl_pipe <= {scl_pipe[SYNC_STAGES-1:0], scl_in};
      sda_pipe <= {sda_pipe[SYNC_STAGES-1:0], sda_in};
    end
  end

  assign scl_now = scl_pipe[SYNC_STAGES-1];
  assign scl_old = scl_pipe[SYNC_STAGES];
  assign sda_now = sda_pipe[SYNC_STAGES-1];
  assign sda_old = sda_pipe[SYNC_STAGES];

  assign sda_lvl   = sda_now;
  assign scl_rise  = scl_now & ~scl_old;
  assign scl_fall  = ~scl_now & scl_old;
  assign start_evt = scl_now & scl_old & sda_old & ~sda_now;
  assign stop_evt  = scl_now & scl_old & ~sda_old & sda_now;

endmodule

// File: rtl/sensor_i2c_ptr.sv
// Register pointer with format check, and the byte lane index within a register.
module sensor_i2c_ptr #(
  parameter int PTR_BITS   = 2,
  parameter int DATA_BYTES = 2,
  localparam int IDX_W     = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                ptr_load_en,
  input  logic [7:0]          ptr_byte,
  input  logic                idx_clear,
  input  logic                idx_step,
  output logic [PTR_BITS-1:0] ptr,
  output logic [IDX_W-1:0]    idx,
  output logic [IDX_W-1:0]    idx_next
);

  logic ptr_ok;

  // The pointer byte is accepted only when every bit above the index is zero
  assign ptr_ok = (ptr_byte[7:PTR_BITS] == '0);

  generate
    if (DATA_BYTES > 1) begin : g_multi
      assign idx_next = (idx == IDX_W'(DATA_BYTES - 1)) ? '0 : idx + 1'b1;
    end else begin : g_single
      assign idx_next = '0;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      ptr <= '0;
      idx <= '0;
    end else begin
      if (ptr_load_en && ptr_ok) ptr <= ptr_byte[PTR_BITS-1:0];
      if (idx_clear)             idx <= '0;
      else if (idx_step)         idx <= idx_next;
    end
  end

endmodule

// File: rtl/sensor_i2c_link.sv
// Bit and byte protocol engine: address match, pointer/data reception, transmit.
module sensor_i2c_link
  import sensor_i2c_pkg::*;
#(
  parameter int STRAP_BITS                 = 3,
  parameter logic [6-STRAP_BITS:0] ADDR_HI = 4'b1001,
  parameter int DATA_BYTES                 = 2,
  localparam int IDX_W                     = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1,
  localparam int REG_W                     = BYTE_W * DATA_BYTES
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  sda_lvl,
  input  logic                  scl_rise,
  input  logic                  scl_fall,
  input  logic                  start_evt,
  input  logic                  stop_evt,
  input  logic [STRAP_BITS-1:0] addr_strap,
  input  logic [REG_W-1:0]      reg_rd_data,
  input  logic [IDX_W-1:0]      idx,
  input  logic [IDX_W-1:0]      idx_next,
  output logic                  ptr_load_en,
  output logic [7:0]            rx_byte,
  output logic                  idx_clear,
  output logic                  idx_step,
  output logic                  sda_drive_low,
  output logic                  reg_wr_en,
  output logic [IDX_W-1:0]      reg_wr_byte,
  output logic [7:0]            reg_wr_data
);

  link_state_t state;
  logic [3:0]  bit_cnt;
  logic [7:0]  tx_byte;
  logic        rw_read;
  logic        first_byte;
  logic        master_ack;
  logic [7:0]  tx_cur, tx_nxt;
  logic        addr_hit;

  // Lane 0 is the most significant byte of the register word
  function automatic logic [7:0] pick_lane(input logic [REG_W-1:0] word,
                                           input logic [IDX_W-1:0] lane);
    logic [7:0] r;
    r = '0;
    for (int k = 0; k < DATA_BYTES; k++) begin
      if (IDX_W'(k) == lane) r = word[BYTE_W*(DATA_BYTES-1-k) +: BYTE_W];
    end
    return r;
  endfunction

  always_comb begin
    tx_cur   = pick_lane(reg_rd_data, idx);
    tx_nxt   = pick_lane(reg_rd_data, idx_next);
    addr_hit = (rx_byte[7:1] == {ADDR_HI, addr_strap});
  end

  always_ff @(posedge clk) begin
    reg_wr_en   <= 1'b0;
    ptr_load_en <= 1'b0;
    idx_clear   <= 1'b0;
    idx_step    <= 1'b0;
    if (rst) begin
      state         <= ST_IDLE;
      bit_cnt       <= '0;
      rx_byte       <= '0;
      tx_byte       <= '0;
      rw_read       <= 1'b0;
      first_byte    <= 1'b0;
      master_ack    <= 1'b0;
      sda_drive_low <= 1'b0;
      reg_wr_byte   <= '0;
      reg_wr_data   <= '0;
    end else if (start_evt) begin
      state         <= ST_ADDR;
      bit_cnt       <= '0;
      sda_drive_low <= 1'b0;
    end else if (stop_evt) begin
      state         <= ST_IDLE;
      sda_drive_low <= 1'b0;
    end else begin
      unique case (state)
        ST_ADDR, ST_WR_BYTE: begin
          if (scl_rise) begin
            rx_byte <= {rx_byte[6:0], sda_lvl};
            bit_cnt <= bit_cnt + 4'd1;
          end else if (scl_fall && bit_cnt == 4'd8) begin
            bit_cnt <= '0;
            if (state == ST_ADDR) begin
              if (addr_hit) begin
                rw_read       <= rx_byte[0];
                first_byte    <= 1'b1;
                idx_clear     <= 1'b1;
                sda_drive_low <= 1'b1;
                state         <= ST_ADDR_ACK;
              end else begin
                state <= ST_IGNORE;
              end
            end else begin
              sda_drive_low <= 1'b1;
              state         <= ST_WR_ACK;
              if (first_byte) begin
                ptr_load_en <= 1'b1;
                first_byte  <= 1'b0;
              end else begin
                reg_wr_en   <= 1'b1;
                reg_wr_data <= rx_byte;
                reg_wr_byte <= idx;
                idx_step    <= 1'b1;
              end
            end
          end
        end
        ST_ADDR_ACK: begin
          if (scl_fall) begin
            bit_cnt <= '0;
            if (rw_read) begin
              tx_byte       <= tx_cur;
              sda_drive_low <= ~tx_cur[7];
              state         <= ST_RD_BYTE;
            end else begin
              sda_drive_low <= 1'b0;
              state         <= ST_WR_BYTE;
            end
          end
        end
        ST_WR_ACK: begin
          if (scl_fall) begin
            sda_drive_low <= 1'b0;
            bit_cnt       <= '0;
            state         <= ST_WR_BYTE;
          end
        end
        ST_RD_BYTE: begin
          if (scl_fall) begin
            if (bit_cnt == 4'd7) begin
              sda_drive_low <= 1'b0;
              bit_cnt       <= '0;
              state         <= ST_RD_ACK;
            end else begin
              sda_drive_low <= ~tx_byte[3'd6 - bit_cnt[2:0]];
              bit_cnt       <= bit_cnt + 4'd1;
            end
          end
        end
        ST_RD_ACK: begin
          if (scl_rise) begin
            master_ack <= ~sda_lvl;
          end else if (scl_fall) begin
            if (master_ack) begin
              tx_byte       <= tx_nxt;
              sda_drive_low <= ~tx_nxt[7];
              idx_step      <= 1'b1;
              bit_cnt       <= '0;
              state         <= ST_RD_BYTE;
            end else begin
              state <= ST_IGNORE;
            end
          end
        end
        default: ;
      endcase
    end
  end

endmodule

// File: rtl/sensor_i2c_target.sv
// Top: two-wire bus target with pointer-addressed register port.
module sensor_i2c_target
  import sensor_i2c_pkg::*;
#(
  parameter int STRAP_BITS                 = 3,
  parameter logic [6-STRAP_BITS:0] ADDR_HI = 4'b1001,
  parameter int PTR_BITS                   = 2,
  parameter int DATA_BYTES                 = 2,
  parameter int SYNC_STAGES                = 2,
  localparam int IDX_W                     = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1,
  localparam int REG_W                     = BYTE_W * DATA_BYTES
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic                  scl_in,
  input  logic                  sda_in,
  input  logic [STRAP_BITS-1:0] addr_strap,
  output logic                  sda_drive_low,
  output logic [PTR_BITS-1:0]   reg_sel,
  input  logic [REG_W-1:0]      reg_rd_data,
  output logic                  reg_wr_en,
  output logic [IDX_W-1:0]      reg_wr_byte,
  output logic [7:0]            reg_wr_data
);

  logic             sda_lvl, scl_rise, scl_fall, start_evt, stop_evt;
  logic             ptr_load_en, idx_clear, idx_step;
  logic [7:0]       ptr_byte;
  logic [IDX_W-1:0] idx, idx_next;

  sensor_i2c_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk       (clk),
    .rst       (rst),
    .scl_in    (scl_in),
    .sda_in    (sda_in),
    .sda_lvl   (sda_lvl),
    .scl_rise  (scl_rise),
    .scl_fall  (scl_fall),
    .start_evt (start_evt),
    .stop_evt  (stop_evt)
  );

  sensor_i2c_ptr #(.PTR_BITS(PTR_BITS), .DATA_BYTES(DATA_BYTES)) u_ptr (
    .clk         (clk),
    .rst         (rst),
    .ptr_load_en (ptr_load_en),
    .ptr_byte    (ptr_byte),
    .idx_clear   (idx_clear),
    .idx_step    (idx_step),
    .ptr         (reg_sel),
    .idx         (idx),
    .idx_next    (idx_next)
  );

  sensor_i2c_link #(
    .STRAP_BITS (STRAP_BITS),
    .ADDR_HI    (ADDR_HI),
    .DATA_BYTES (DATA_BYTES)
  ) u_link (
    .clk           (clk),
    .rst           (rst),
    .sda_lvl       (sda_lvl),
    .scl_rise      (scl_rise),
    .scl_fall      (scl_fall),
    .start_evt     (start_evt),
    .stop_evt      (stop_evt),
    .addr_strap    (addr_strap),
    .reg_rd_data   (reg_rd_data),
    .idx           (idx),
    .idx_next      (idx_next),
    .ptr_load_en   (ptr_load_en),
    .rx_byte       (ptr_byte),
    .idx_clear     (idx_clear),
    .idx_step      (idx_step),
    .sda_drive_low (sda_drive_low),
    .reg_wr_en     (reg_wr_en),
    .reg_wr_byte   (reg_wr_byte),
    .reg_wr_data   (reg_wr_data)
  );

endmodule

// File: rtl/sensor_i2c_target_chk.sv
module sensor_i2c_target_chk #(
  parameter int PTR_BITS   = 2,
  parameter int DATA_BYTES = 2,
  localparam int IDX_W     = (DATA_BYTES > 1) ? $clog2(DATA_BYTES) : 1
) (
  input logic                clk,
  input logic                rst,
  input logic                scl_fall,
  input logic                start_evt,
  input logic                stop_evt,
  input logic                sda_drive_low,
  input logic                reg_wr_en,
  input logic [IDX_W-1:0]    reg_wr_byte,
  input logic [PTR_BITS-1:0] reg_sel,
  input logic                ptr_load_en,
  input logic [7:0]          ptr_byte
);

  AST_START_RELEASES: assert property (@(posedge clk) disable iff (rst) start_evt |=> !sda_drive_low); // R1
  AST_STOP_RELEASES: assert property (@(posedge clk) disable iff (rst) stop_evt |=> !sda_drive_low); // R2
  AST_PTR_ONLY_VALID: assert property (@(posedge clk) disable iff (rst) !$stable(reg_sel) |-> ($past(ptr_load_en) && ($past(ptr_byte[7:PTR_BITS]) == '0))); // R6
  AST_WR_LANE_RANGE: assert property (@(posedge clk) disable iff (rst) reg_wr_en |-> (int'(reg_wr_byte) < DATA_BYTES)); // R7
  AST_DRIVE_AFTER_FALL: assert property (@(posedge clk) disable iff (rst) !$stable(sda_drive_low) |-> $past(scl_fall)); // R11
  AST_WR_SINGLE_PULSE: assert property (@(posedge clk) disable iff (rst) reg_wr_en |=> !reg_wr_en); // R12

endmodule

bind sensor_i2c_target sensor_i2c_target_chk #(.PTR_BITS(PTR_BITS), .DATA_BYTES(DATA_BYTES)) u_chk (
  .clk           (clk),
  .rst           (rst),
  .scl_fall      (scl_fall),
  .start_evt     (start_evt),
  .stop_evt      (stop_evt),
  .sda_drive_low (sda_drive_low),
  .reg_wr_en     (reg_wr_en),
  .reg_wr_byte   (reg_wr_byte),
  .reg_sel       (reg_sel),
  .ptr_load_en   (ptr_load_en),
  .ptr_byte      (ptr_byte)
);

// File: tb/sensor_i2c_target_test.sv
`timescale 1ns/1ps
module sensor_i2c_target_test;

  localparam int Q = 4;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        master_scl = 1'b1;
  logic        master_sda = 1'b1;
  logic [2:0]  strap = 3'b101;
  logic        sda_drive_low;
  logic [1:0]  reg_sel;
  logic [15:0] reg_rd_data;
  logic        reg_wr_en;
  logic [0:0]  reg_wr_byte;
  logic [7:0]  reg_wr_data;
  logic        sda_bus;

  logic [15:0] bank [4];
  logic [15:0] exp_bank [4];
  logic [1:0]  exp_ptr;
  logic [7:0]  wbuf [8];
  int n_chk = 0, n_bad = 0;
  int wr_count = 0, exp_wr = 0;
  int r11_viol = 0, r12_viol = 0;
  logic prev_drv = 1'b0, prev_wr = 1'b0;
  bit done = 0;

  always #10 clk = ~clk;

  assign sda_bus     = master_sda & ~sda_drive_low;
  assign reg_rd_data = bank[reg_sel];

  sensor_i2c_target uut (
    .clk           (clk),
    .rst           (rst),
    .scl_in        (master_scl),
    .sda_in        (sda_bus),
    .addr_strap    (strap),
    .sda_drive_low (sda_drive_low),
    .reg_sel       (reg_sel),
    .reg_rd_data   (reg_rd_data),
    .reg_wr_en     (reg_wr_en),
    .reg_wr_byte   (reg_wr_byte),
    .reg_wr_data   (reg_wr_data)
  );

  function automatic logic [15:0] seed_val(input int k);
    return 16'hA5C3 ^ (16'(k) * 16'h1357);
  endfunction

  function automatic logic [7:0] exp_byte(input logic [1:0] p, input int i);
    return (i % 2 == 0) ? exp_bank[p][15:8] : exp_bank[p][7:0];
  endfunction

  // Register bank model driven only through the write port; also port monitors
  always @(negedge clk) begin
    if (rst) begin
      for (int k = 0; k < 4; k++) bank[k] <= seed_val(k);
    end else begin
      if (reg_wr_en) begin
        if (reg_wr_byte == 1'b0) bank[reg_sel][15:8] <= reg_wr_data;
        else                     bank[reg_sel][7:0]  <= reg_wr_data;
        wr_count <= wr_count + 1;
      end
      if (sda_drive_low != prev_drv && master_scl) r11_viol <= r11_viol + 1;
      if (reg_wr_en && prev_wr) r12_viol <= r12_viol + 1;
      prev_drv <= sda_drive_low;
      prev_wr  <= reg_wr_en;
    end
  end

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bit_clk(input logic b, output logic r);
    master_sda = b;
    wait_clk(Q);
    master_scl = 1'b1;
    wait_clk(Q);
    r = sda_bus;
    wait_clk(Q);
    master_scl = 1'b0;
    wait_clk(Q);
  endtask

  task automatic do_start();
    master_sda = 1'b1;
    wait_clk(Q);
    master_scl = 1'b1;
    wait_clk(Q);
    master_sda = 1'b0;
    wait_clk(Q);
    master_scl = 1'b0;
    wait_clk(Q);
  endtask

  task automatic do_stop();
    master_sda = 1'b0;
    wait_clk(Q);
    master_scl = 1'b1;
    wait_clk(Q);
    master_sda = 1'b1;
    wait_clk(Q);
  endtask

  task automatic send_byte(input logic [7:0] b, output logic ack);
    logic r;
    for (int i = 7; i >= 0; i--) bit_clk(b[i], r);
    bit_clk(1'b1, r);
    ack = ~r;
  endtask

  task automatic recv_byte(input logic give_ack, output logic [7:0] b);
    logic r;
    for (int i = 7; i >= 0; i--) begin
      bit_clk(1'b1, r);
      b[i] = r;
    end
    bit_clk(~give_ack, r);
  endtask

  task automatic txn_write(input logic [7:0] ptrb, input int n, input bit with_stop);
    logic ack;
    int lane;
    do_start();
    send_byte({4'b1001, strap, 1'b0}, ack);
    check(ack, "R3 write address ack", 32'(ack), 1);
    send_byte(ptrb, ack);
    check(ack, "R5/R6 pointer byte ack", 32'(ack), 1);
    if (ptrb[7:2] == 6'd0) exp_ptr = ptrb[1:0];
    lane = 0;
    for (int i = 0; i < n; i++) begin
      send_byte(wbuf[i], ack);
      check(ack, "R5 data byte ack", 32'(ack), 1);
      if (lane == 0) exp_bank[exp_ptr][15:8] = wbuf[i];
      else           exp_bank[exp_ptr][7:0]  = wbuf[i];
      lane = 1 - lane;
      exp_wr++;
    end
    if (with_stop) do_stop();
    wait_clk(2);
    check(reg_sel == exp_ptr, "R6/R10 pointer after write", 32'(reg_sel), 32'(exp_ptr));
    for (int k = 0; k < 4; k++)
      check(bank[k] == exp_bank[k], "R7 register contents", 32'(bank[k]), 32'(exp_bank[k]));
  endtask

  task automatic txn_read(input int n);
    logic ack;
    logic [7:0] b;
    do_start();
    send_byte({4'b1001, strap, 1'b1}, ack);
    check(ack, "R3 read address ack", 32'(ack), 1);
    for (int i = 0; i < n; i++) begin
      recv_byte(i < n - 1, b);
      check(b == exp_byte(exp_ptr, i), "R8 read byte", 32'(b), 32'(exp_byte(exp_ptr, i)));
    end
    do_stop();
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=timeout expected=finish");
      report();
    end
  end

  initial begin
    logic ack, r;
    logic [7:0] b;
    int base;
    void'($urandom(32'd20240611));
    for (int k = 0; k < 4; k++) exp_bank[k] = seed_val(k);
    exp_ptr = 2'd0;
    wait_clk(5);
    // Reset state (R10)
    check(sda_drive_low == 1'b0, "R10 reset drive", 32'(sda_drive_low), 0);
    check(reg_sel == 2'd0, "R10 reset pointer", 32'(reg_sel), 0);
    check(reg_wr_en == 1'b0, "R10 reset write strobe", 32'(reg_wr_en), 0);
    rst = 1'b0;
    wait_clk(5);

    // R10: read with no pointer write returns register 0
    txn_read(2);

    // R4: wrong strap bits, then wrong prefix
    do_start();
    send_byte({4'b1001, strap ^ 3'b001, 1'b0}, ack);
    check(!ack, "R4 foreign address nack", 32'(ack), 0);
    send_byte(8'h01, ack);
    check(!ack, "R4 ignored byte nack", 32'(ack), 0);
    send_byte(8'h5A, ack);
    check(!ack, "R4 ignored byte nack", 32'(ack), 0);
    do_stop();
    wait_clk(2);
    check(wr_count == exp_wr, "R4 no write", 32'(wr_count), 32'(exp_wr));
    check(reg_sel == exp_ptr, "R4 pointer kept", 32'(reg_sel), 32'(exp_ptr));
    do_start();
    send_byte({4'b1011, strap, 1'b1}, ack);
    check(!ack, "R4 wrong prefix nack", 32'(ack), 0);
    recv_byte(1'b1, b);
    check(b == 8'hFF, "R4 line never driven", 32'(b), 32'hFF);
    do_stop();

    // R5 R7 R8: pointer 2, two data bytes, read back
    wbuf[0] = 8'h3C; wbuf[1] = 8'hE1;
    txn_write(8'h02, 2, 1'b1);
    txn_read(2);

    // R6: malformed pointer acknowledged, selection kept, data to old register
    wbuf[0] = 8'h77;
    txn_write(8'h41, 1, 1'b1);
    check(reg_sel == 2'd2, "R6 pointer unchanged", 32'(reg_sel), 2);

    // R8: read wraps across five bytes
    txn_read(5);

    // R7: three data bytes wrap to the MSB lane
    wbuf[0] = 8'h11; wbuf[1] = 8'h22; wbuf[2] = 8'h99;
    txn_write(8'h01, 3, 1'b1);
    check(bank[1] == 16'h9922, "R7 lane wrap", 32'(bank[1]), 32'h9922);

    // R1: pointer write followed by repeated START into a read
    txn_write(8'h03, 0, 1'b0);
    txn_read(3);

    // R9: NACK ends the read, later clocks see a released line
    do_start();
    send_byte({4'b1001, strap, 1'b1}, ack);
    check(ack, "R3 read address ack", 32'(ack), 1);
    recv_byte(1'b0, b);
    check(b == exp_byte(exp_ptr, 0), "R9 last byte", 32'(b), 32'(exp_byte(exp_ptr, 0)));
    base = 0;
    for (int i = 0; i < 9; i++) begin
      bit_clk(1'b1, r);
      if (!r) base++;
    end
    check(base == 0, "R9 released after nack", 32'(base), 0);
    do_stop();

    // R2: STOP inside the address byte, then inside a data byte
    do_start();
    for (int i = 0; i < 4; i++) bit_clk(1'b1, r);
    do_stop();
    wait_clk(2);
    check(sda_drive_low == 1'b0, "R2 released after stop", 32'(sda_drive_low), 0);
    do_start();
    send_byte({4'b1001, strap, 1'b0}, ack);
    send_byte(8'h00, ack);
    exp_ptr = 2'd0;
    for (int i = 0; i < 3; i++) bit_clk(1'b0, r);
    do_stop();
    wait_clk(2);
    check(wr_count == exp_wr, "R2 partial byte not written", 32'(wr_count), 32'(exp_wr));
    check(bank[0] == exp_bank[0], "R2 register untouched", 32'(bank[0]), 32'(exp_bank[0]));
    txn_read(2);

    // R3: strap change moves the address
    do_start();
    send_byte({4'b1001, 3'b010, 1'b1}, ack);
    check(!ack, "R3 old strap mismatch", 32'(ack), 0);
    do_stop();
    strap = 3'b010;
    wait_clk(4);
    txn_read(1);

    // Seeded random transactions
    for (int t = 0; t < 30; t++) begin
      if ($urandom % 2 == 0) begin
        logic [7:0] pb;
        int n;
        pb = ($urandom % 4 == 0) ? 8'($urandom) : 8'($urandom % 4);
        n  = $urandom % 4;
        for (int i = 0; i < n; i++) wbuf[i] = 8'($urandom);
        txn_write(pb, n, 1'b1);
      end else begin
        txn_read(1 + $urandom % 4);
      end
    end

    wait_clk(4);
    check(wr_count == exp_wr, "R7 write strobe count", 32'(wr_count), 32'(exp_wr));
    check(r11_viol == 0, "R11 drive change with SCL high", 32'(r11_viol), 0);
    check(r12_viol == 0, "R12 strobe longer than a cycle", 32'(r12_viol), 0);
    done = 1;
    report();
  end

endmodule